// File: doc/BRIEF.md
# Video Clamp and Moire Pulse Generator

This block drives a single video output pin from three asynchronous timing inputs: a horizontal sync, a horizontal flyback and a vertical flyback. The pin has two uses. In clamp mode it carries a pulse of programmable length, which the black-level restore circuit uses. The pulse is launched by either the falling edge of horizontal sync (back porch) or its rising edge (pseudo-front porch), and its active level can be inverted. In moire mode the same pin carries a square wave. The wave flips once per line on the flyback, and its phase changes from one frame to the next, so that the moire pattern on the screen is reduced.

Static configuration inputs select the function. They are an enable, a polarity bit, a 2-bit mode code and a 2-bit width code. Each timing input passes through a synchroniser and an edge detector before it reaches the pulse counter or the moire state. All control pins are plain levels, and no data stream crosses the block's edge.

Top module: `vidclamp_top`

## Requirements
- R1: After reset, with polarity 0, the pin is low and the moire state is 0.
- R2: Mode codes 01 and 11 select back porch. A falling edge of hsync starts a clamp pulse, and a rising edge does not.
- R3: Mode code 10 selects pseudo-front porch. A rising edge of hsync starts a clamp pulse, and a falling edge does not.
- R4: Width codes 00, 01, 10 and 11 give pulses of 0, 4, 8 and 16 clock cycles. Code 00 produces no pulse at all.
- R5: The pin first shows the active clamp level on the third clock edge after the trigger edge reaches the input. This is two synchroniser stages plus one counter load.
- R6: With polarity 1 the inactive level is high and the active clamp level is low. With polarity 0 both levels are the other way round.
- R7: While enable is 0 the pin stays at the inactive level (equal to the polarity bit), in both clamp and moire modes.
- R8: A trigger edge that arrives during an active pulse reloads the full width, which lengthens the pulse.
- R9: Mode code 00 selects moire. The pin then equals the moire state, whatever the polarity bit. The state inverts on every rising edge of horizontal flyback.
- R10: On each falling edge of vertical flyback, the moire state becomes the inverse of the value it took at the previous such edge. The first such edge after reset sets it to 1. The number of horizontal flyback pulses in between has no effect on this. A vertical edge takes priority over a horizontal edge that arrives at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (24 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| hfly_in | input | 1 | Horizontal flyback, asynchronous |
| vfly_in | input | 1 | Vertical flyback, asynchronous |
| cfg_en | input | 1 | Output enable |
| cfg_inv | input | 1 | Clamp polarity; also the inactive level |
| cfg_mode | input | 2 | 00 moire, 01/11 back porch, 10 pseudo-front porch |
| cfg_width | input | 2 | Clamp width code |
| pin_out | output | 1 | Shared clamp / moire output |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a width unit of 4 cycles. With these values every pulse (at most 16 cycles) and the 3-cycle launch delay fit inside short sampling windows, so each pulse length and each start cycle can be counted exactly. The short widths also make it possible to retrigger in the middle of a pulse and to run several moire frames with different line counts in a few hundred cycles.

// File: rtl/vidclamp_pkg.sv
package vidclamp_pkg;
  typedef enum logic [1:0] {
    MODE_MOIRE  = 2'b00,
    MODE_BACK   = 2'b01,
    MODE_FRONT  = 2'b10,
    MODE_BACK_X = 2'b11
  } vc_mode_e;

  function automatic int unsigned width_cycles(input logic [1:0] code, input int unsigned unit);
    case (code)
      2'b00:   return 0;
      2'b01:   return unit;
      2'b10:   return 2 * unit;
      default: return 4 * unit;
    endcase
  endfunction
endpackage

// File: rtl/vidclamp_sync_edge.sv
module vidclamp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;
  logic              lvl;

  assign lvl = shreg[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], din};
      prev_q <= lvl;
    end
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/vidclamp_pulse.sv
module vidclamp_pulse #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] load_val,
  output logic             active
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (trig)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/vidclamp_moire.sv
module vidclamp_moire (
  input  logic clk,
  input  logic rst_n,
  input  logic line_edge,
  input  logic frame_edge,
  output logic state_q,
  output logic phase_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      phase_q <= 1'b0;
    end else if (frame_edge) begin
      state_q <= ~phase_q;
      phase_q <= ~phase_q;
    end else if (line_edge) begin
      state_q <= ~state_q;
    end
  end
endmodule

// File: rtl/vidclamp_top.sv
module vidclamp_top #(
  parameter int SYNC_STAGES = 2,
  parameter int WIDTH_UNIT  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_in,
  input  logic       hfly_in,
  input  logic       vfly_in,
  input  logic       cfg_en,
  input  logic       cfg_inv,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_width,
  output logic       pin_out
);
  import vidclamp_pkg::*;

  localparam int MAX_W = 4 * WIDTH_UNIT;
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic hs_rise, hs_fall, hfb_rise, hfb_fall_unused, vfb_rise_unused, vfb_fall;
  logic trig, clamp_active, moire_q, frame_ph;
  logic [CNT_W-1:0] load_val;
  vc_mode_e mode;

  vidclamp_sync_edge #(.STAGES(SYNC_STAGES)) u_hs (
    .clk(clk), .rst_n(rst_n), .din(hsync_in), .rise(hs_rise), .fall(hs_fall));
  vidclamp_sync_edge #(.STAGES(SYNC_STAGES)) u_hfb (
    .clk(clk), .rst_n(rst_n), .din(hfly_in), .rise(hfb_rise), .fall(hfb_fall_unused));
  vidclamp_sync_edge #(.STAGES(SYNC_STAGES)) u_vfb (
    .clk(clk), .rst_n(rst_n), .din(vfly_in), .rise(vfb_rise_unused), .fall(vfb_fall));

  assign mode     = vc_mode_e'(cfg_mode);
  assign trig     = (mode == MODE_FRONT) ? hs_rise : hs_fall;
  assign load_val = CNT_W'(width_cycles(cfg_width, WIDTH_UNIT));

  vidclamp_pulse #(.CNT_W(CNT_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(trig), .load_val(load_val), .active(clamp_active));

  vidclamp_moire u_moire (
    .clk(clk), .rst_n(rst_n), .line_edge(hfb_rise), .frame_edge(vfb_fall),
    .state_q(moire_q), .phase_q(frame_ph));

  always_comb begin
    if (!cfg_en)                 pin_out = cfg_inv;
    else if (mode == MODE_MOIRE) pin_out = moire_q;
    else                         pin_out = clamp_active ^ cfg_inv;
  end
endmodule

module vidclamp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_en,
  input logic       cfg_inv,
  input logic [1:0] cfg_width,
  input logic       pin_out,
  input logic       trig,
  input logic       clamp_active,
  input logic       hfb_rise,
  input logic       vfb_fall,
  input logic       moire_q,
  input logic       frame_ph
);
  // R4
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_width != 2'b00) |=> clamp_active);
  // R4
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cfg_width == 2'b00) |=> !clamp_active);
  // R7
  disabled_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (pin_out == cfg_inv));
  // R9
  line_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hfb_rise && !vfb_fall) |=> (moire_q != $past(moire_q)));
  // R10
  frame_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vfb_fall |=> (moire_q == frame_ph));
  // R10
  moire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hfb_rise && !vfb_fall) |=> $stable(moire_q));
endmodule

bind vidclamp_top vidclamp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_inv(cfg_inv), .cfg_width(cfg_width),
  .pin_out(pin_out), .trig(trig), .clamp_active(clamp_active), .hfb_rise(hfb_rise),
  .vfb_fall(vfb_fall), .moire_q(moire_q), .frame_ph(frame_ph));

// File: tb/vidclamp_top_test.sv
module vidclamp_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, hfly_in = 1'b0, vfly_in = 1'b0;
  logic cfg_en = 1'b1, cfg_inv = 1'b0;
  logic [1:0] cfg_mode = 2'b01, cfg_width = 2'b01;
  logic pin_out;
  int checks = 0, fails = 0;
  logic exp_m = 1'b0, exp_ph = 1'b0;

  always #4 clk = ~clk;

  vidclamp_top uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hfly_in(hfly_in), .vfly_in(vfly_in),
    .cfg_en(cfg_en), .cfg_inv(cfg_inv), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .pin_out(pin_out));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Set config and idle hsync level, then drive the opposite level and measure.
  task automatic pulse_case(input string req, input logic [1:0] mode, input logic [1:0] wcode,
                            input logic inv, input logic en, input logic new_lvl,
                            input int exp_len);
    int cnt = 0, first = -1;
    cfg_mode = mode; cfg_width = wcode; cfg_inv = inv; cfg_en = en;
    hsync_in = ~new_lvl;
    idle(25);
    hsync_in = new_lvl;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (pin_out != inv) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    check(req, cnt, exp_len);
    if (exp_len > 0) check("R5 start cycle", first, 3);
  endtask

  task automatic t_reset;
    check("R1 pin after reset", int'(pin_out), 0);
    cfg_mode = 2'b00;
    @(negedge clk);
    check("R1 moire state after reset", int'(pin_out), 0);
    cfg_mode = 2'b01;
  endtask

  task automatic t_back_porch;
    pulse_case("R2 fall triggers (01)", 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 4);
    pulse_case("R2 rise ignored (01)",  2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 0);
    pulse_case("R2 fall triggers (11)", 2'b11, 2'b10, 1'b0, 1'b1, 1'b0, 8);
  endtask

  task automatic t_front_porch;
    pulse_case("R3 rise triggers", 2'b10, 2'b01, 1'b0, 1'b1, 1'b1, 4);
    pulse_case("R3 fall ignored",  2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_widths;
    pulse_case("R4 width code 00", 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 0);
    pulse_case("R4 width code 10", 2'b10, 2'b10, 1'b0, 1'b1, 1'b1, 8);
    pulse_case("R4 width code 11", 2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 16);
  endtask

  task automatic t_polarity;
    pulse_case("R6 inverted pulse", 2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 8);
    check("R6 inactive high", int'(pin_out), 1);
  endtask

  task automatic t_disable;
    pulse_case("R7 clamp gated", 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 0);
    check("R7 clamp gated level", int'(pin_out), 1);
  endtask

  task automatic t_retrigger;
    int cnt = 0;
    cfg_mode = 2'b01; cfg_width = 2'b11; cfg_inv = 1'b0; cfg_en = 1'b1;
    hsync_in = 1'b1;
    idle(25);
    hsync_in = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (pin_out) cnt++;
      if (i == 4) hsync_in = 1'b1;
      if (i == 8) hsync_in = 1'b0;
    end
    check("R8 retrigger length", cnt, 24);
  endtask

  task automatic hfb_pulse;
    hfly_in = 1'b1; idle(5); hfly_in = 1'b0; idle(5);
    exp_m = ~exp_m;
  endtask

  task automatic vfb_fall_ev;
    vfly_in = 1'b0; idle(5);
    exp_m = ~exp_ph; exp_ph = ~exp_ph;
  endtask

  task automatic t_moire;
    cfg_mode = 2'b00; cfg_en = 1'b1; cfg_inv = 1'b1;
    idle(3);
    for (int i = 0; i < 3; i++) begin
      hfb_pulse();
      check("R9 line toggle", int'(pin_out), int'(exp_m));
    end
    vfly_in = 1'b1; idle(5);
    vfb_fall_ev();
    check("R10 first frame flip", int'(pin_out), 1);
    vfly_in = 1'b1; idle(5);
    hfb_pulse(); hfb_pulse();
    vfb_fall_ev();
    check("R10 second frame flip", int'(pin_out), 0);
    hfb_pulse(); hfb_pulse(); hfb_pulse();
    check("R9 toggles while vfb low", int'(pin_out), int'(exp_m));
    vfly_in = 1'b1; idle(5);
    vfb_fall_ev();
    check("R10 third frame flip", int'(pin_out), 1);
    // simultaneous line and frame edge: frame wins
    vfly_in = 1'b1; idle(5);
    hfly_in = 1'b1; vfly_in = 1'b0; idle(5);
    exp_m = ~exp_ph; exp_ph = ~exp_ph;
    hfly_in = 1'b0; idle(5);
    check("R10 frame beats line", int'(pin_out), int'(exp_m));
    cfg_en = 1'b0; cfg_inv = 1'b0;
    hfb_pulse();
    check("R7 moire gated", int'(pin_out), 0);
    cfg_en = 1'b1;
    @(negedge clk);
    check("R9 state ran while gated", int'(pin_out), int'(exp_m));
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_back_porch();
        t_front_porch();
        t_widths();
        t_polarity();
        t_disable();
        t_retrigger();
        t_moire();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule